// File: doc/BRIEF.md
# Setup Packet Buffer With Write Priority

This block stores the eight setup-stage bytes of a USB control endpoint. A receive engine pushes bytes in from the bus side. The first byte of a packet carries a start marker. Each later byte is accepted only while a packet is in progress, and the slots fill in arrival order. Once the last slot is written, a data-valid flag tells the CPU side that a complete request is ready. The CPU then pulls it out one byte per read strobe, and each result comes back on the next clock.

The bus side must never be stalled, so it always wins. A start marker ends whatever the CPU side is doing. The read pointer goes back to slot 0 and the data-valid flag drops until the new packet is complete. If the CPU was part-way through reading the old packet, a sticky abort bit is set. Software clears that bit by pulsing a write-one-to-clear input. Any read that cannot be served returns zero and raises a one-cycle underrun flag. This covers reads with no complete packet, reads during a write and reads past the last byte. A clear input drops the stored packet and any write in progress. It is meant for bus reset and cable reconnect.

Top module: `setup_pkt_buf`

## Requirements
- R1: A byte with `wr_en_i` and `wr_sop_i` high goes to slot 0 and opens a packet. Each following byte with `wr_en_i` high and `wr_sop_i` low goes to the next slot. The cycle after the byte for slot 7, `data_valid_o` is 1.
- R2: While `data_valid_o` is 1, each `rd_en_i` strobe returns the next slot, in order from slot 0 to slot 7. The byte appears on `rd_data_o` one cycle later, with `rd_valid_o` at 1.
- R3: A start byte always takes priority. A read in the same cycle is refused. From the next cycle, `data_valid_o` is 0 and a later read begins at slot 0 of the new packet.
- R4: `abort_o` sets when a start byte is accepted while `data_valid_o` is 1 and a read is in progress. A read is in progress when 1 to 7 bytes have been read, or when `rd_en_i` is high in that same cycle. It does not set if no byte or all 8 bytes were read.
- R5: `abort_o` stays set until `abort_clr_i` is high at a clock edge. If a new abort happens in that same cycle, the bit stays set.
- R6: A read that is not served returns `rd_data_o` = 0 with `rd_valid_o` = 0, and `underrun_o` = 1 for exactly that response cycle. A read is not served when `data_valid_o` is 0, when all 8 bytes were already read, or when the read is refused under R3.
- R7: `clr_i` has priority over any write in the same cycle. From the next cycle, `data_valid_o` is 0, any open packet is closed and the read pointer is at slot 0.
- R8: A byte with `wr_en_i` high and `wr_sop_i` low, arriving while no packet is open, is ignored. Stored data and flags are unchanged.
- R9: After reset, all outputs are 0.
- R10: A start byte that arrives while a packet is still open restarts the packet at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus-side byte strobe |
| wr_sop_i | input | 1 | Marks the first byte of a setup packet |
| wr_data_i | input | 8 | Bus-side byte |
| rd_en_i | input | 1 | CPU read strobe |
| rd_data_o | output | 8 | Read byte, one cycle after the strobe |
| rd_valid_o | output | 1 | Read byte is valid |
| underrun_o | output | 1 | Read was not served |
| data_valid_o | output | 1 | A complete packet is held |
| abort_o | output | 1 | Sticky: a read was pre-empted |
| abort_clr_i | input | 1 | Clears abort_o |
| clr_i | input | 1 | Empties the buffer |

## Verification
The bench pre-empts a read at several points: in the same cycle as the read strobe, after three bytes, after zero bytes and after all eight. A design that ties abort to the wrong condition sets the bit after a fully drained packet, or misses it on the same-cycle collision. It also drives clears, stray continuation bytes after a clear, and restarts part-way through a packet. A design with wrong priorities lets a cleared packet resume, or stores bytes in the wrong slots. Reads during a write and reads past slot 7 must return zero with the underrun flag. A design that reads from the array during a write would hand out stale or torn bytes.

// File: rtl/spb_pkg.sv
package spb_pkg;
  parameter int unsigned SPB_DEPTH = 8;
  parameter int unsigned SPB_DW    = 8;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_GRANT  = 2'd1,
    RD_REFUSE = 2'd2
  } rd_outcome_e;
endpackage

// File: rtl/spb_store.sv
module spb_store #(
  parameter int unsigned DEPTH = spb_pkg::SPB_DEPTH,
  parameter int unsigned DW    = spb_pkg::SPB_DW,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q[g] <= '0;
      else if (we_i && waddr_i == PW'(g))        slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/spb_wr_ctrl.sv
module spb_wr_ctrl #(
  parameter int unsigned DEPTH = spb_pkg::SPB_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sop_i,
  input  logic          clr_i,
  output logic          mem_we_o,
  output logic [PW-1:0] mem_waddr_o,
  output logic          sop_acc_o,
  output logic          wr_active_o,
  output logic          done_o
);
  logic [PW-1:0] wr_ptr_q;
  logic          active_q, done_q;
  logic          sop_acc, byte_acc, last_byte;

  assign sop_acc   = wr_en_i & wr_sop_i & ~clr_i;
  assign byte_acc  = wr_en_i & ~wr_sop_i & active_q & ~clr_i;
  assign last_byte = byte_acc && (wr_ptr_q == PW'(DEPTH-1));

  assign mem_we_o    = sop_acc | byte_acc;
  assign mem_waddr_o = sop_acc ? '0 : wr_ptr_q;
  assign sop_acc_o   = sop_acc;
  assign wr_active_o = active_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (sop_acc) begin
      wr_ptr_q <= PW'(1);
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (last_byte) begin
      wr_ptr_q <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b1;
    end else if (byte_acc) begin
      wr_ptr_q <= wr_ptr_q + PW'(1);
    end
  end

  a_r1_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte |=> done_q);
  a_r7_clear_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_q && !active_q));
  a_r8_stray_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sop_i && !active_q && !clr_i) |=> ($stable(done_q) && !active_q));
  a_r10_restart_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_acc |=> (active_q && wr_ptr_q == PW'(1) && !done_q));
endmodule

// File: rtl/spb_rd_ctrl.sv
module spb_rd_ctrl #(
  parameter int unsigned DEPTH = spb_pkg::SPB_DEPTH,
  parameter int unsigned DW    = spb_pkg::SPB_DW,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          done_i,
  input  logic          sop_acc_i,
  input  logic          clr_i,
  input  logic          abort_clr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [PW-1:0] mem_raddr_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          underrun_o,
  output logic          abort_o
);
  import spb_pkg::*;

  logic [PW:0]   rd_ptr_q;
  logic [DW-1:0] rd_data_q;
  logic          rd_valid_q, underrun_q, abort_q;
  logic          has_left, in_progress, abort_set;
  rd_outcome_e   outcome;

  assign has_left    = rd_ptr_q < (PW+1)'(DEPTH);
  assign in_progress = done_i && has_left && (rd_ptr_q != '0 || rd_en_i);
  assign abort_set   = sop_acc_i && in_progress;
  assign mem_raddr_o = rd_ptr_q[PW-1:0];

  always_comb begin
    outcome = RD_IDLE;
    if (rd_en_i) begin
      if (done_i && has_left && !sop_acc_i && !clr_i) outcome = RD_GRANT;
      else                                            outcome = RD_REFUSE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q   <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      rd_valid_q <= (outcome == RD_GRANT);
      underrun_q <= (outcome == RD_REFUSE);
      rd_data_q  <= (outcome == RD_GRANT) ? mem_rdata_i : '0;
      if (clr_i || sop_acc_i)        rd_ptr_q <= '0;
      else if (outcome == RD_GRANT)  rd_ptr_q <= rd_ptr_q + (PW+1)'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          abort_q <= 1'b0;
    else if (abort_set)   abort_q <= 1'b1;
    else if (abort_clr_i) abort_q <= 1'b0;
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign underrun_o = underrun_q;
  assign abort_o    = abort_q;

  a_r2_valid_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_q |-> $past(done_i));
  a_r3_write_blocks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_acc_i |=> (!rd_valid_q && rd_ptr_q == '0));
  a_r5_abort_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_q && !abort_clr_i) |=> abort_q);
  a_r6_underrun_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_q |-> (rd_data_q == '0 && !rd_valid_q));
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_valid_q, underrun_q}));
endmodule

// File: rtl/setup_pkt_buf.sv
module setup_pkt_buf #(
  parameter int unsigned DEPTH = spb_pkg::SPB_DEPTH,
  parameter int unsigned DW    = spb_pkg::SPB_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sop_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          underrun_o,
  output logic          data_valid_o,
  output logic          abort_o,
  input  logic          abort_clr_i,
  input  logic          clr_i
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic          mem_we, sop_acc, wr_active, done;
  logic [PW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_rdata;

  spb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sop_i(wr_sop_i),
    .clr_i(clr_i), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .sop_acc_o(sop_acc), .wr_active_o(wr_active), .done_o(done)
  );

  spb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(wr_data_i), .raddr_i(mem_raddr), .rdata_o(mem_rdata)
  );

  spb_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .done_i(done),
    .sop_acc_i(sop_acc), .clr_i(clr_i), .abort_clr_i(abort_clr_i),
    .mem_rdata_i(mem_rdata), .mem_raddr_o(mem_raddr), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .underrun_o(underrun_o), .abort_o(abort_o)
  );

  assign data_valid_o = done;

  a_r3_no_valid_while_writing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_active |-> !data_valid_o);
endmodule

// File: tb/sim_setup_pkt_buf.sv
module sim_setup_pkt_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sop = 1'b0, rd_en = 1'b0, abort_clr = 1'b0, clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, underrun, data_valid, abort_f;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R9";

  // reference model state
  logic [7:0] m_mem [8];
  int  m_wptr = 0, m_rptr = 0;
  bit  m_wact = 0, m_done = 0, m_abort = 0, m_rvalid = 0, m_under = 0;
  logic [7:0] m_rdata = '0;

  always #5 clk = ~clk;

  setup_pkt_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sop_i(wr_sop),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .underrun_o(underrun), .data_valid_o(data_valid),
    .abort_o(abort_f), .abort_clr_i(abort_clr), .clr_i(clr)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit sop, byt, grant, busy;
    sop  = wr_en && wr_sop && !clr;
    byt  = wr_en && !wr_sop && m_wact && !clr;
    busy = m_done && m_rptr < 8 && (m_rptr != 0 || rd_en);
    grant = rd_en && m_done && m_rptr < 8 && !sop && !clr;
    m_rvalid = grant;
    m_under  = rd_en && !grant;
    m_rdata  = grant ? m_mem[m_rptr] : 8'h00;
    if (grant) m_rptr++;
    if (sop && busy) m_abort = 1;
    else if (abort_clr) m_abort = 0;
    if (clr) begin
      m_wact = 0; m_wptr = 0; m_done = 0; m_rptr = 0;
    end else if (sop) begin
      m_mem[0] = wr_data; m_wptr = 1; m_wact = 1; m_done = 0; m_rptr = 0;
    end else if (byt) begin
      m_mem[m_wptr] = wr_data;
      if (m_wptr == 7) begin m_wact = 0; m_done = 1; m_wptr = 0; end
      else m_wptr++;
    end
  endtask

  task automatic compare();
    check(cur_req, "rd_valid",   rd_valid,   m_rvalid);
    check(cur_req, "underrun",   underrun,   m_under);
    check(cur_req, "rd_data",    rd_data,    m_rdata);
    check(cur_req, "data_valid", data_valid, m_done);
    check(cur_req, "abort",      abort_f,    m_abort);
  endtask

  // one clock with the given inputs; compare at the following negedge
  task automatic cyc(bit we, bit sop, logic [7:0] d, bit re, bit ac, bit cl);
    wr_en = we; wr_sop = sop; wr_data = d; rd_en = re; abort_clr = ac; clr = cl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    wr_en = 0; wr_sop = 0; rd_en = 0; abort_clr = 0; clr = 0;
  endtask

  task automatic write_pkt(logic [7:0] base);
    for (int i = 0; i < 8; i++) cyc(1, i == 0, base + 8'(i * 17), 0, 0, 0);
  endtask

  task automatic reads(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    cur_req = "R9";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    cur_req = "R1";
    write_pkt(8'h10);
    check("R1", "data_valid after 8 bytes", data_valid, 1);

    cur_req = "R2";
    reads(8);
    check("R2", "last byte", rd_data, 8'h10 + 8'(7 * 17));
    cur_req = "R6";
    reads(2);
    check("R6", "overread underrun", underrun, 1);

    // pre-empt after three reads, same-cycle collision
    cur_req = "R1";
    write_pkt(8'h40);
    cur_req = "R2";
    reads(3);
    cur_req = "R4";
    cyc(1, 1, 8'hA0, 1, 0, 0);
    check("R4", "abort after partial read", abort_f, 1);
    check("R3", "read refused on sop", rd_valid, 0);
    check("R3", "data_valid drops", data_valid, 0);
    cur_req = "R6";
    reads(2);
    check("R6", "read during write", rd_data, 0);
    cur_req = "R1";
    for (int i = 1; i < 8; i++) cyc(1, 0, 8'hA0 + 8'(i), 0, 0, 0);
    cur_req = "R3";
    cyc(0, 0, 0, 1, 0, 0);
    check("R3", "new packet from slot 0", rd_data, 8'hA0);
    check("R5", "abort still set", abort_f, 1);
    cur_req = "R5";
    cyc(0, 0, 0, 0, 1, 0);
    check("R5", "abort cleared", abort_f, 0);

    // sop with rd_en in same cycle while nothing read: abort
    cur_req = "R4";
    write_pkt(8'h01);
    cyc(1, 1, 8'h55, 1, 1, 0);
    check("R5", "set wins over clear", abort_f, 1);
    cyc(0, 0, 0, 0, 1, 0);
    for (int i = 1; i < 8; i++) cyc(1, 0, 8'h55, 0, 0, 0);
    // no read at all, then sop: no abort
    cyc(1, 1, 8'h22, 0, 0, 0);
    check("R4", "no abort when nothing read", abort_f, 0);
    for (int i = 1; i < 8; i++) cyc(1, 0, 8'h22 + 8'(i), 0, 0, 0);
    reads(8);
    cyc(1, 1, 8'h33, 0, 0, 0);
    check("R4", "no abort after full drain", abort_f, 0);

    // restart mid-packet
    cur_req = "R10";
    cyc(1, 0, 8'h34, 0, 0, 0);
    cyc(1, 1, 8'hC0, 0, 0, 0);
    for (int i = 1; i < 8; i++) cyc(1, 0, 8'hC0 + 8'(i), 0, 0, 0);
    check("R10", "valid after restart", data_valid, 1);
    reads(8);
    check("R10", "slot 7 after restart", rd_data, 8'hC7);

    // clear mid-write, stray bytes ignored
    cur_req = "R7";
    write_pkt(8'h70);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 1, 8'h90, 0, 0, 0);
    cyc(1, 0, 8'h91, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    check("R7", "cleared", data_valid, 0);
    cur_req = "R8";
    for (int i = 0; i < 8; i++) cyc(1, 0, 8'hEE, 0, 0, 0);
    check("R8", "stray bytes ignored", data_valid, 0);
    reads(1);
    check("R8", "read after stray", underrun, 1);
    cur_req = "R7";
    cyc(1, 1, 8'h11, 0, 0, 1);
    for (int i = 1; i < 8; i++) cyc(1, 0, 8'h11, 0, 0, 0);
    check("R7", "clear beats sop", data_valid, 0);
    write_pkt(8'h05);
    reads(1);
    check("R7", "read pointer restarted", rd_data, 8'h05);

    summary();
  end
endmodule